// File: doc/BRIEF.md
# Power Supply Fault Supervisor

This block is the digital supervisor of a flyback PWM controller. It takes the results of the analog comparators as synchronous one-bit flags and decides when the power stage may switch. The flags cover the supply turn-on, turn-off and over-voltage levels, the enable pin, the die-temperature hot and cool levels, the per-cycle current-limit hit, an open current-sense pin and a secondary-rectifier short spike. A strobe marks the end of each switching cycle.

The outputs are a switching permit, a gate pull-low request and a 3-bit fault code. Each fault recovers in its own way. A supply drop returns to lockout. A disable is filtered and then parks the block until the pin comes back. Over-voltage and the fast faults take a short auto-retry pause. An overload takes a long hiccup pause. Over-temperature only pauses switching until the cool flag is seen. Every retry goes back through lockout, so the turn-on flag is needed again before switching resumes.

The clock is 1 MHz by default. All filter windows, the retry pauses and the fast-fault count are parameters.

Top module: `psu_guard`

## Requirements
- R1: After reset the permit is 0, the pull-low request is 1 and the code is 1 (lockout). From lockout, the permit rises only on a clock where the turn-on flag is high. It then reads 1 with code 0.
- R2: While running or paused, the turn-off flag drops the block to lockout (code 1, pull-low 1) on the next clock. This takes priority over every fault except disable.
- R3: An enable input held low for DEGLITCH_CYC consecutive clocks shuts the block down with code 2 and pull-low 1. A shorter low pulse has no effect. The block stays off, even if the turn-on flag is high, until enable returns high. It then goes to lockout.
- R4: If OLP_CYC consecutive running clocks pass without a clean cycle, the block enters a hiccup with code 3 for HICCUP_CYC clocks. It then goes to lockout with code 1.
- R5: A clean cycle resets the overload timer. A clean cycle is a cycle-end strobe with no current-limit hit since the previous strobe.
- R6: An over-voltage flag held for DEGLITCH_CYC consecutive running clocks stops switching with code 4 for RETRY_CYC clocks, then goes to lockout. A shorter burst has no effect.
- R7: The hot flag pauses switching with code 4+1 = 5 and pull-low 0. Releasing the hot flag does not resume switching. Switching resumes, with code 0, only when the cool flag is high.
- R8: The open-sense flag seen at FAST_N consecutive cycle-end strobes stops switching with code 6, followed by a RETRY_CYC pause. A strobe without the flag restarts the count.
- R9: The secondary-short flag trips the same way with code 7. It wins over open-sense on the same strobe.
- R10: Code values: 0 none, 1 lockout, 2 disabled, 3 overload, 4 over-voltage, 5 over-temperature, 6 open sense, 7 secondary short. The order of priority is: disable, turn-off, over-voltage, secondary short, open sense, overload, over-temperature.
- R11: The pull-low request is 1 only in lockout and when disabled. The permit and the pull-low request are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_on_i | input | 1 | Supply above turn-on level |
| vdd_off_i | input | 1 | Supply below turn-off level |
| vdd_ovp_i | input | 1 | Supply above over-voltage level |
| en_i | input | 1 | Enable pin high or floating |
| hot_i | input | 1 | Die above hot threshold |
| cool_i | input | 1 | Die below cool threshold |
| cyc_end_i | input | 1 | One-clock strobe at end of a switching cycle |
| ilim_i | input | 1 | Current limit hit |
| cs_open_i | input | 1 | Current-sense pin open, sampled at the strobe |
| sec_short_i | input | 1 | Secondary-short spike, sampled at the strobe |
| sw_permit_o | output | 1 | Switching permitted |
| pull_low_o | output | 1 | Gate pull-low request |
| fault_o | output | 3 | Active fault code |

## Verification
A wrong state or counter shows at the ports on the clock edge after the decision, because all three outputs are registered from the next state. A filter counter that is never cleared shows as an early trip: over-voltage or disable acts before its window has passed, or the overload timer fires even though clean cycles arrive. A counter that is cleared wrongly shows as a trip that never comes within the window. A fault-priority or retry-timer error shows as a wrong code, or as lockout being reached too early or too late after the pause.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;
  typedef enum logic [2:0] {
    FC_NONE   = 3'd0,
    FC_UVLO   = 3'd1,
    FC_DIS    = 3'd2,
    FC_OLP    = 3'd3,
    FC_OVP    = 3'd4,
    FC_OTP    = 3'd5,
    FC_CSOPEN = 3'd6,
    FC_SSHORT = 3'd7
  } fault_e;

  typedef enum logic [2:0] {
    ST_LOCK   = 3'd0,
    ST_RUN    = 3'd1,
    ST_PAUSE  = 3'd2,
    ST_HICCUP = 3'd3,
    ST_OFF    = 3'd4
  } state_e;
endpackage

// File: rtl/psu_guard_persist.sv
// Counts consecutive clocks of a level; fires on the LIMIT-th one.
module psu_guard_persist #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic level,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !level) cnt <= '0;
    else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
  end

  assign trip = level && !clr && (cnt == CW'(LIMIT - 1));

  // R3 R4 R6: the window counter never passes its limit
  assert_persist_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/psu_guard_streak.sv
// Counts consecutive cycle-end strobes with a flag set.
module psu_guard_streak #(
  parameter int COUNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(COUNT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (strobe) begin
      if (!flag) cnt <= '0;
      else if (cnt != CW'(COUNT - 1)) cnt <= cnt + 1'b1;
    end
  end

  assign trip = !clr && strobe && flag && (cnt == CW'(COUNT - 1));

  // R8: a strobe without the flag always restarts the streak
  assert_streak_reset_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe && !flag && !clr) |=> (cnt == '0));
endmodule

// File: rtl/psu_guard.sv
module psu_guard
  import psu_guard_pkg::*;
#(
  parameter int DEGLITCH_CYC = 20,
  parameter int OLP_CYC      = 56000,
  parameter int HICCUP_CYC   = 4 * 56000,
  parameter int RETRY_CYC    = 1000,
  parameter int FAST_N       = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vdd_on_i,
  input  logic       vdd_off_i,
  input  logic       vdd_ovp_i,
  input  logic       en_i,
  input  logic       hot_i,
  input  logic       cool_i,
  input  logic       cyc_end_i,
  input  logic       ilim_i,
  input  logic       cs_open_i,
  input  logic       sec_short_i,
  output logic       sw_permit_o,
  output logic       pull_low_o,
  output logic [2:0] fault_o
);
  localparam int HMAX = (HICCUP_CYC > RETRY_CYC) ? HICCUP_CYC : RETRY_CYC;
  localparam int HW   = $clog2(HMAX + 1);

  state_e state_q, state_d;
  fault_e code_q, code_d;
  logic [HW-1:0] hic_q, hic_d;
  logic running, hit_q, clean_cyc;
  logic dis_trip, ovp_trip, olp_trip;
  logic [1:0] fast_flag, fast_trip;

  assign running = (state_q == ST_RUN);

  // current-limit seen in the cycle under way
  always_ff @(posedge clk) begin
    if (rst || !running || cyc_end_i) hit_q <= 1'b0;
    else if (ilim_i) hit_q <= 1'b1;
  end
  assign clean_cyc = cyc_end_i && !hit_q && !ilim_i;

  psu_guard_persist #(.LIMIT(DEGLITCH_CYC)) u_dis (
    .clk(clk), .rst(rst), .clr(state_q == ST_OFF), .level(!en_i), .trip(dis_trip));

  psu_guard_persist #(.LIMIT(DEGLITCH_CYC)) u_ovp (
    .clk(clk), .rst(rst), .clr(!running), .level(vdd_ovp_i), .trip(ovp_trip));

  psu_guard_persist #(.LIMIT(OLP_CYC)) u_olp (
    .clk(clk), .rst(rst), .clr(!running || clean_cyc), .level(1'b1), .trip(olp_trip));

  assign fast_flag = {sec_short_i, cs_open_i};

  for (genvar g = 0; g < 2; g++) begin : g_fast
    psu_guard_streak #(.COUNT(FAST_N)) u_streak (
      .clk(clk), .rst(rst), .clr(!running), .strobe(cyc_end_i),
      .flag(fast_flag[g]), .trip(fast_trip[g]));
  end

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    hic_d   = hic_q;
    if (dis_trip) begin
      state_d = ST_OFF;
      code_d  = FC_DIS;
    end else begin
      unique case (state_q)
        ST_LOCK: if (vdd_on_i) begin
          state_d = ST_RUN;
          code_d  = FC_NONE;
        end
        ST_RUN: begin
          if (vdd_off_i) begin
            state_d = ST_LOCK;
            code_d  = FC_UVLO;
          end else if (ovp_trip) begin
            state_d = ST_HICCUP;
            code_d  = FC_OVP;
            hic_d   = HW'(RETRY_CYC - 1);
          end else if (fast_trip[1]) begin
            state_d = ST_HICCUP;
            code_d  = FC_SSHORT;
            hic_d   = HW'(RETRY_CYC - 1);
          end else if (fast_trip[0]) begin
            state_d = ST_HICCUP;
            code_d  = FC_CSOPEN;
            hic_d   = HW'(RETRY_CYC - 1);
          end else if (olp_trip) begin
            state_d = ST_HICCUP;
            code_d  = FC_OLP;
            hic_d   = HW'(HICCUP_CYC - 1);
          end else if (hot_i) begin
            state_d = ST_PAUSE;
            code_d  = FC_OTP;
          end
        end
        ST_PAUSE: begin
          if (vdd_off_i) begin
            state_d = ST_LOCK;
            code_d  = FC_UVLO;
          end else if (cool_i) begin
            state_d = ST_RUN;
            code_d  = FC_NONE;
          end
        end
        ST_HICCUP: begin
          if (hic_q == '0) begin
            state_d = ST_LOCK;
            code_d  = FC_UVLO;
          end else begin
            hic_d = hic_q - 1'b1;
          end
        end
        ST_OFF: if (en_i) begin
          state_d = ST_LOCK;
          code_d  = FC_UVLO;
        end
        default: begin
          state_d = ST_LOCK;
          code_d  = FC_UVLO;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_LOCK;
      code_q      <= FC_UVLO;
      hic_q       <= '0;
      sw_permit_o <= 1'b0;
      pull_low_o  <= 1'b1;
    end else begin
      state_q     <= state_d;
      code_q      <= code_d;
      hic_q       <= hic_d;
      sw_permit_o <= (state_d == ST_RUN);
      pull_low_o  <= (state_d == ST_LOCK) || (state_d == ST_OFF);
    end
  end

  assign fault_o = code_q;

  // R1: switching starts only from turn-on (lockout) or cool (pause)
  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_permit_o) |-> ($past(vdd_on_i) || $past(cool_i)));

  // R2: turn-off stops switching on the next clock
  assert_uvlo_R2: assert property (@(posedge clk) disable iff (rst)
    (sw_permit_o && vdd_off_i) |=> !sw_permit_o);

  // R7: hot while running stops switching on the next clock
  assert_otp_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_permit_o && hot_i) |=> !sw_permit_o);

  // R11: permit and pull-low never together
  assert_pull_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(sw_permit_o && pull_low_o));

  // R10: a stopped block always reports a reason
  assert_code_R10: assert property (@(posedge clk) disable iff (rst)
    !sw_permit_o |-> (fault_o != 3'd0));
endmodule

// File: tb/psu_guard_bench.sv
`timescale 1ns/1ps
module psu_guard_bench;
  localparam int DEG = 20;
  localparam int OLP = 200;
  localparam int HIC = 800;
  localparam int RTY = 50;
  localparam int FN  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vdd_on = 0, vdd_off = 0, vdd_ovp = 0, en = 1, hot = 0, cool = 0;
  logic cyc_end = 0, ilim = 0, cs_open = 0, sec_short = 0;
  logic sw, pl;
  logic [2:0] code;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  psu_guard #(.DEGLITCH_CYC(DEG), .OLP_CYC(OLP), .HICCUP_CYC(HIC),
              .RETRY_CYC(RTY), .FAST_N(FN)) u_psu_guard (
    .clk(clk), .rst(rst), .vdd_on_i(vdd_on), .vdd_off_i(vdd_off),
    .vdd_ovp_i(vdd_ovp), .en_i(en), .hot_i(hot), .cool_i(cool),
    .cyc_end_i(cyc_end), .ilim_i(ilim), .cs_open_i(cs_open),
    .sec_short_i(sec_short), .sw_permit_o(sw), .pull_low_o(pl), .fault_o(code));

  // vector: {on,off,ovp,en,hot,cool}, wait clocks, exp permit, exp pull, exp code
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    {6'b000100, 8'd5,  1'b0, 1'b1, 3'd1}, // R1 lockout holds
    {6'b100100, 8'd3,  1'b1, 1'b0, 3'd0}, // R1 turn-on starts
    {6'b000100, 8'd5,  1'b1, 1'b0, 3'd0}, // R1 keeps running
    {6'b000110, 8'd3,  1'b0, 1'b0, 3'd5}, // R7 hot pause
    {6'b000100, 8'd3,  1'b0, 1'b0, 3'd5}, // R7 hot gone, no cool
    {6'b000101, 8'd3,  1'b1, 1'b0, 3'd0}, // R7 cool resumes
    {6'b001100, 8'd10, 1'b1, 1'b0, 3'd0}, // R6 short ovp burst
    {6'b000100, 8'd2,  1'b1, 1'b0, 3'd0}, // R6 burst ends
    {6'b001100, 8'd10, 1'b1, 1'b0, 3'd0}, // R6 window restarted
    {6'b001100, 8'd15, 1'b0, 1'b0, 3'd4}, // R6 ovp trip
    {6'b000100, 8'd60, 1'b0, 1'b1, 3'd1}, // R6 retry ends in lockout
    {6'b100100, 8'd3,  1'b1, 1'b0, 3'd0}, // R1 restart
    {6'b000000, 8'd10, 1'b1, 1'b0, 3'd0}, // R3 short disable ignored
    {6'b000100, 8'd2,  1'b1, 1'b0, 3'd0}, // R3
    {6'b000000, 8'd25, 1'b0, 1'b1, 3'd2}, // R3 disable honoured
    {6'b100000, 8'd5,  1'b0, 1'b1, 3'd2}, // R3 turn-on ignored while off
    {6'b100100, 8'd3,  1'b1, 1'b0, 3'd0}, // R3 re-enable then start
    {6'b010110, 8'd3,  1'b0, 1'b1, 3'd1}, // R2 turn-off beats hot
    {6'b100100, 8'd3,  1'b1, 1'b0, 3'd0}, // R1
    {6'b010100, 8'd3,  1'b0, 1'b1, 3'd1}, // R2 turn-off while running
    {6'b100100, 8'd3,  1'b1, 1'b0, 3'd0}, // R1
    {6'b000110, 8'd3,  1'b0, 1'b0, 3'd5}, // R7
    {6'b010110, 8'd3,  1'b0, 1'b1, 3'd1}  // R2 turn-off during pause
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: permit/pull/code act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_run();
    vdd_on = 1; vdd_off = 0; vdd_ovp = 0; en = 1; hot = 0; cool = 0;
    clocks(3);
    vdd_on = 0;
    clocks(1);
  endtask

  // one switching cycle of 10 clocks; strobe on the last clock
  task automatic one_cycle(input logic hit);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cyc_end = (i == 9);
      ilim    = hit && (i == 3);
    end
    @(negedge clk);
    cyc_end = 0;
    ilim    = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  initial begin
    clocks(3);
    rst = 0;
    clocks(1);
    check("R1 reset", {sw, pl, code}, {1'b0, 1'b1, 3'd1});

    for (int v = 0; v < NV; v++) begin
      {vdd_on, vdd_off, vdd_ovp, en, hot, cool} = VEC[v][18:13];
      clocks(int'(VEC[v][12:5]));
      check($sformatf("table vector %0d", v), {sw, pl, code}, VEC[v][4:0]);
    end

    // R4 overload: limit hit every cycle
    vdd_off = 0; hot = 0;
    go_run();
    for (int c = 0; c < 16; c++) one_cycle(1'b1);
    check("R4 before window", {sw, pl, code}, {1'b1, 1'b0, 3'd0});
    for (int c = 0; c < 4; c++) one_cycle(1'b1);
    check("R4 overload trip", {sw, pl, code}, {1'b0, 1'b0, 3'd3});
    clocks(400);
    check("R4 hiccup still off", {sw, pl, code}, {1'b0, 1'b0, 3'd3});
    clocks(500);
    check("R4 hiccup ends", {sw, pl, code}, {1'b0, 1'b1, 3'd1});

    // R5 clean cycle every fifth keeps the timer short
    go_run();
    for (int c = 0; c < 60; c++) one_cycle((c % 5) != 4);
    check("R5 clean cycles reset timer", {sw, pl, code}, {1'b1, 1'b0, 3'd0});

    // R8 open sense, interrupted streak
    cs_open = 1;
    for (int c = 0; c < 3; c++) one_cycle(1'b0);
    cs_open = 0;
    one_cycle(1'b0);
    cs_open = 1;
    for (int c = 0; c < 3; c++) one_cycle(1'b0);
    check("R8 interrupted streak", {sw, pl, code}, {1'b1, 1'b0, 3'd0});
    one_cycle(1'b0);
    check("R8 open sense trip", {sw, pl, code}, {1'b0, 1'b0, 3'd6});
    cs_open = 0;
    clocks(60);

    // R9 secondary short beats open sense
    go_run();
    cs_open = 1; sec_short = 1;
    for (int c = 0; c < 3; c++) one_cycle(1'b0);
    check("R9 before count", {sw, pl, code}, {1'b1, 1'b0, 3'd0});
    one_cycle(1'b0);
    check("R9 short trip priority", {sw, pl, code}, {1'b0, 1'b0, 3'd7});
    cs_open = 0; sec_short = 0;
    clocks(60);
    check("R10 retry to lockout", {sw, pl, code}, {1'b0, 1'b1, 3'd1});

    // R11 reset mid-run
    go_run();
    rst = 1;
    clocks(2);
    rst = 0;
    clocks(1);
    check("R11 reset mid-run", {sw, pl, code}, {1'b0, 1'b1, 3'd1});

    finish_run();
  end
endmodule